// File: doc/BRIEF.md
# Shared-Memory Accumulator Processor Core

This block is a small stored-program processor whose instructions and data live in the same single-port word memory. A single accumulator holds every result. Each instruction moves through fetch, decode and execute in strict order, and the next instruction does not start until the current one has finished. Every transfer between the program counter, the memory address register, the memory data register, the instruction register and the accumulator takes a clock cycle of its own. An observer can therefore follow each step on the memory port.

The core drives the address and write data of one external memory and receives its read data one cycle after an address is presented. An instruction word is 16 bits: a 4-bit operation code sits at the top, and a 12-bit operand field below it names a memory word. The core offers load, store, add, subtract, bitwise AND, an unconditional jump, a jump taken when the accumulator is zero, and a halt. A halted flag and a debug copy of the accumulator show how a program ended.

Top module: `acc_core`

## Requirements
- R1: An active-high synchronous reset clears the program counter, memory address, memory data, instruction and accumulator registers to zero. It lowers the halted flag and mem_we, and execution then restarts with a fetch from address 0. Reset also leaves the halted state.
- R2: The operation code is word bits 15:12 and the operand field is bits 11:0. Only the low ADDR_W bits of the operand field form the memory address. The codes are 0 halt, 1 load, 2 store, 3 add, 4 subtract, 5 AND, 6 jump and 7 jump-if-zero.
- R3: A fetch takes four separate cycles: program counter to address register, a wait for the memory, read data to data register, then data register to instruction register together with an increment of the program counter. Decode takes one further cycle. An instruction with no memory operand therefore takes 6 cycles, and a halt takes 5 cycles to raise the halted flag.
- R4: Load, add, subtract and AND copy the operand address into the address register, wait one cycle, then capture memory into the data register before they execute. Each of these instructions takes 9 cycles.
- R5: Load places the memory word in the accumulator. Add, subtract and AND place accumulator+word, accumulator-word (both modulo 2^16) and the bitwise AND in the accumulator.
- R6: Store copies the accumulator into the data register and then writes it to the operand address. mem_we is high for exactly one cycle, and mem_wdata equals the accumulator while it is high. Store reads no operand and takes 8 cycles.
- R7: Jump loads the operand address into the program counter. The next instruction is fetched from that address.
- R8: Jump-if-zero tests the accumulator as it stands when it executes. If the accumulator is zero, the jump is taken. Otherwise execution continues at the next sequential word.
- R9: Operation codes 8 to 15 are no-operations. They leave the accumulator and memory unchanged and take 6 cycles.
- R10: After a halt, the halted flag stays high and the accumulator, address and memory stay frozen with mem_we low until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | ADDR_W | Memory address, the contents of the address register |
| mem_wdata | output | 16 | Write data, the contents of the data register |
| mem_rdata | input | 16 | Read data, valid one cycle after mem_addr |
| mem_we | output | 1 | Write enable, one cycle per store |
| halted | output | 1 | High once a halt instruction has been decoded |
| acc_dbg | output | 16 | Current accumulator value |

## Verification
The bench builds the core with ADDR_W set to 8, so its memory model is a 256-word array it can seed and inspect fully. Operand fields with set bits above bit 7 show that only the low address bits are used. With this small store, the bench can run the arithmetic program over an 8-by-8 grid of edge operand values (zero, one, sign boundary, all ones and mixed patterns) and compute each sum, difference and AND in the bench. It also runs both jump paths for every value, and the no-operation test for every unused operation code.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int WORD_W  = 16;
    localparam int OPC_W   = 4;
    localparam int FIELD_W = WORD_W - OPC_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [OPC_W-1:0]  opc_t;

    localparam opc_t OPC_HALT  = 4'd0;
    localparam opc_t OPC_LOAD  = 4'd1;
    localparam opc_t OPC_STORE = 4'd2;
    localparam opc_t OPC_ADD   = 4'd3;
    localparam opc_t OPC_SUB   = 4'd4;
    localparam opc_t OPC_AND   = 4'd5;
    localparam opc_t OPC_JMP   = 4'd6;
    localparam opc_t OPC_JZ    = 4'd7;

    // Instruction groups, as the sequencer sees them
    typedef enum logic [2:0] {
        CL_HALT,
        CL_MEMRD,
        CL_STORE,
        CL_JUMP,
        CL_JZ,
        CL_NOP
    } op_class_e;

    typedef enum logic [1:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_SUB,
        ALU_AND
    } alu_op_e;

    // Register-transfer steps of the sequencer
    typedef enum logic [3:0] {
        PH_F_ADDR,
        PH_F_WAIT,
        PH_F_CAPT,
        PH_F_IR,
        PH_DECODE,
        PH_O_ADDR,
        PH_O_WAIT,
        PH_O_CAPT,
        PH_EXEC,
        PH_S_DATA,
        PH_S_WRITE,
        PH_HALT
    } phase_e;

    // One strobe for each register transfer
    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic mdr_from_mem;
        logic mdr_from_acc;
        logic ir_from_mdr;
        logic pc_step;
        logic pc_jump;
        logic acc_write;
        logic mem_write;
    } ctl_t;

    function automatic op_class_e classify(opc_t opc);
        case (opc)
            OPC_HALT:                     return CL_HALT;
            OPC_LOAD, OPC_ADD,
            OPC_SUB, OPC_AND:             return CL_MEMRD;
            OPC_STORE:                    return CL_STORE;
            OPC_JMP:                      return CL_JUMP;
            OPC_JZ:                       return CL_JZ;
            default:                      return CL_NOP;
        endcase
    endfunction

    function automatic alu_op_e alu_select(opc_t opc);
        case (opc)
            OPC_ADD: return ALU_ADD;
            OPC_SUB: return ALU_SUB;
            OPC_AND: return ALU_AND;
            default: return ALU_PASS;
        endcase
    endfunction

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
(
    input  alu_op_e op,
    input  word_t   a,
    input  word_t   b,
    output word_t   y
);

    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            default:  y = b;
        endcase
    end

endmodule

// File: rtl/acc_regs.sv
module acc_regs
    import acc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  word_t             mem_rdata,
    input  word_t             alu_y,
    output logic [ADDR_W-1:0] mar,
    output word_t             mdr,
    output word_t             ir,
    output word_t             acc
);

    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] operand;

    assign operand = ir[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            mar <= '0;
            mdr <= '0;
            ir  <= '0;
            acc <= '0;
        end else begin
            if (ctl.mar_from_pc) begin
                mar <= pc;
            end else if (ctl.mar_from_ir) begin
                mar <= operand;
            end

            if (ctl.mdr_from_mem) begin
                mdr <= mem_rdata;
            end else if (ctl.mdr_from_acc) begin
                mdr <= acc;
            end

            if (ctl.ir_from_mdr) begin
                ir <= mdr;
            end

            if (ctl.pc_jump) begin
                pc <= operand;
            end else if (ctl.pc_step) begin
                pc <= pc + 1'b1;
            end

            if (ctl.acc_write) begin
                acc <= alu_y;
            end
        end
    end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  opc_t opc,
    input  logic acc_zero,
    output ctl_t ctl,
    output logic halted
);

    phase_e    phase, phase_nxt;
    op_class_e cls;

    assign cls    = classify(opc);
    assign halted = (phase == PH_HALT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_F_ADDR;
        end else begin
            phase <= phase_nxt;
        end
    end

    always_comb begin
        ctl       = '0;
        phase_nxt = phase;
        unique case (phase)
            PH_F_ADDR: begin
                ctl.mar_from_pc = 1'b1;
                phase_nxt       = PH_F_WAIT;
            end
            PH_F_WAIT: begin
                phase_nxt = PH_F_CAPT;
            end
            PH_F_CAPT: begin
                ctl.mdr_from_mem = 1'b1;
                phase_nxt        = PH_F_IR;
            end
            PH_F_IR: begin
                ctl.ir_from_mdr = 1'b1;
                ctl.pc_step     = 1'b1;
                phase_nxt       = PH_DECODE;
            end
            PH_DECODE: begin
                case (cls)
                    CL_HALT:            phase_nxt = PH_HALT;
                    CL_MEMRD, CL_STORE: phase_nxt = PH_O_ADDR;
                    default:            phase_nxt = PH_EXEC;
                endcase
            end
            PH_O_ADDR: begin
                ctl.mar_from_ir = 1'b1;
                phase_nxt       = (cls == CL_STORE) ? PH_S_DATA : PH_O_WAIT;
            end
            PH_O_WAIT: begin
                phase_nxt = PH_O_CAPT;
            end
            PH_O_CAPT: begin
                ctl.mdr_from_mem = 1'b1;
                phase_nxt        = PH_EXEC;
            end
            PH_EXEC: begin
                ctl.acc_write = (cls == CL_MEMRD);
                ctl.pc_jump   = (cls == CL_JUMP) || ((cls == CL_JZ) && acc_zero);
                phase_nxt     = PH_F_ADDR;
            end
            PH_S_DATA: begin
                ctl.mdr_from_acc = 1'b1;
                phase_nxt        = PH_S_WRITE;
            end
            PH_S_WRITE: begin
                ctl.mem_write = 1'b1;
                phase_nxt     = PH_F_ADDR;
            end
            PH_HALT: begin
                phase_nxt = PH_HALT;
            end
            default: begin
                phase_nxt = PH_F_ADDR;
            end
        endcase
    end

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    output logic              mem_we,
    output logic              halted,
    output logic [15:0]       acc_dbg
);

    ctl_t              ctl;
    logic [ADDR_W-1:0] mar;
    word_t             mdr;
    word_t             ir;
    word_t             acc;
    word_t             alu_y;
    opc_t              opc;
    alu_op_e           alu_op;

    assign opc    = ir[WORD_W-1 -: OPC_W];
    assign alu_op = alu_select(opc);

    acc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .opc      (opc),
        .acc_zero (acc == '0),
        .ctl      (ctl),
        .halted   (halted)
    );

    acc_regs #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .alu_y     (alu_y),
        .mar       (mar),
        .mdr       (mdr),
        .ir        (ir),
        .acc       (acc)
    );

    acc_alu u_alu (
        .op (alu_op),
        .a  (acc),
        .b  (mdr),
        .y  (alu_y)
    );

    assign mem_addr  = mar;
    assign mem_wdata = mdr;
    assign mem_we    = ctl.mem_write;
    assign acc_dbg   = acc;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [15:0]       mem_wdata,
    input logic              mem_we,
    input logic              halted,
    input logic [15:0]       acc_dbg
);

    // R1: one reset edge leaves a cleared, running core
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (acc_dbg == '0 && mem_addr == '0 && !halted && !mem_we));

    // R6: a store writes for a single cycle
    assert_we_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R6: the written word is the accumulator
    assert_store_acc_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata == acc_dbg));

    // R10: halt is sticky and freezes the visible state
    assert_halt_hold_R10: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(acc_dbg) && $stable(mem_addr)));

    // R10: no write happens while halted
    assert_halt_nowrite_R10: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we);

endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .halted    (halted),
    .acc_dbg   (acc_dbg)
);

// File: tb/sim_acc_core.sv
`timescale 1ns/1ps
module sim_acc_core;

    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata;
    logic          mem_we;
    logic          halted;
    logic [15:0]   acc_dbg;

    logic          ld_en   = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [15:0]   ld_data = '0;
    logic [15:0]   mem [0:DEPTH-1];

    int   checks = 0;
    int   errors = 0;
    int   we_cnt;
    int   we_dbl;
    logic done = 1'b0;

    logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                              16'hFFFF, 16'h00FF, 16'h1234, 16'hA5A5};

    always #10 clk = ~clk;

    // Memory model: one-cycle read latency, bench load port has priority
    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    acc_core #(.ADDR_W(AW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .halted    (halted),
        .acc_dbg   (acc_dbg)
    );

    function automatic logic [15:0] ins(int op, int a);
        return {op[3:0], a[11:0]};
    endfunction

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic poke(int a, logic [15:0] d);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_addr = a[AW-1:0];
        ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
    endtask

    // Release reset and count rising edges until halted is seen
    task automatic run(output int n);
        logic prev;
        @(negedge clk);
        rst    = 1'b0;
        n      = 0;
        we_cnt = 0;
        we_dbl = 0;
        prev   = 1'b0;
        while (!halted && n < 3000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (mem_we) begin
                we_cnt++;
                if (prev) we_dbl++;
            end
            prev = mem_we;
        end
        check("R10", "halt reached", {15'd0, halted}, 16'd1);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        logic [15:0] a_hold;
        logic [AW-1:0] addr_hold;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "acc after reset", acc_dbg, 16'h0000);
        check("R1", "addr after reset", {8'd0, mem_addr}, 16'h0000);
        check("R1", "halted after reset", {15'd0, halted}, 16'd0);
        check("R1", "we after reset", {15'd0, mem_we}, 16'd0);

        // R4 R5 R6: arithmetic program over an 8x8 value grid
        poke(0, ins(1, 100)); poke(1, ins(3, 101)); poke(2, ins(2, 102));
        poke(3, ins(1, 100)); poke(4, ins(4, 101)); poke(5, ins(2, 103));
        poke(6, ins(1, 100)); poke(7, ins(5, 101)); poke(8, ins(2, 104));
        poke(9, ins(0, 0));
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                hold_reset();
                poke(100, vals[i]); poke(101, vals[j]);
                poke(102, 16'hDEAD); poke(103, 16'hDEAD); poke(104, 16'hDEAD);
                run(n);
                check("R5", "add", mem[102], vals[i] + vals[j]);
                check("R5", "sub", mem[103], vals[i] - vals[j]);
                check("R5", "and", mem[104], vals[i] & vals[j]);
                check("R4", "cycles", n[15:0], 16'd83);
                check("R6", "write pulses", we_cnt[15:0], 16'd3);
                check("R6", "back-to-back writes", we_dbl[15:0], 16'd0);
            end
        end

        // R1: reset leaves halt and clears a nonzero accumulator
        hold_reset();
        poke(100, 16'h4321);
        run(n);
        hold_reset();
        @(negedge clk);
        check("R1", "acc cleared from halt", acc_dbg, 16'h0000);
        check("R1", "halt cleared", {15'd0, halted}, 16'd0);

        // R8: jump-if-zero, both paths
        poke(0, ins(1, 100)); poke(1, ins(7, 5)); poke(2, ins(1, 101));
        poke(3, ins(2, 102)); poke(4, ins(0, 0)); poke(5, ins(1, 103));
        poke(6, ins(2, 102)); poke(7, ins(0, 0));
        poke(101, 16'h1111); poke(103, 16'h2222);
        for (int i = 0; i < 8; i++) begin
            hold_reset();
            poke(100, vals[i]); poke(102, 16'hDEAD);
            run(n);
            check("R8", "jz result", mem[102], (vals[i] == 16'h0) ? 16'h2222 : 16'h1111);
            check("R8", "jz cycles", n[15:0], 16'd37);
        end

        // R7: unconditional jump skips words 2 and 3
        poke(0, ins(1, 100)); poke(1, ins(6, 4)); poke(2, ins(2, 102));
        poke(3, ins(0, 0)); poke(4, ins(3, 100)); poke(5, ins(2, 103));
        poke(6, ins(0, 0));
        for (int i = 0; i < 8; i++) begin
            hold_reset();
            poke(100, vals[i]); poke(102, 16'hDEAD); poke(103, 16'hDEAD);
            run(n);
            check("R7", "skipped store", mem[102], 16'hDEAD);
            check("R7", "target result", mem[103], vals[i] + vals[i]);
            check("R7", "jmp cycles", n[15:0], 16'd37);
        end

        // R9 R2: unused codes do nothing; high operand bits are dropped
        poke(0, ins(1, 12'hF64)); poke(2, ins(2, 12'hA66)); poke(3, ins(0, 0));
        poke(100, 16'h1357);
        for (int k = 8; k < 16; k++) begin
            hold_reset();
            poke(1, ins(k, 101)); poke(101, 16'h5A5A); poke(102, 16'hDEAD);
            run(n);
            check("R9", "nop leaves memory", mem[101], 16'h5A5A);
            check("R9", "nop leaves acc", acc_dbg, 16'h1357);
            check("R2", "clipped operand", mem[102], 16'h1357);
            check("R9", "nop cycles", n[15:0], 16'd28);
            check("R6", "single write", we_cnt[15:0], 16'd1);
        end

        // R3 R10: halt timing and freeze
        poke(0, ins(0, 0)); poke(1, ins(1, 100)); poke(2, ins(2, 102));
        hold_reset();
        poke(102, 16'hDEAD);
        run(n);
        check("R3", "halt cycles", n[15:0], 16'd5);
        poke(0, ins(6, 2)); poke(1, ins(0, 0)); poke(2, ins(1, 100));
        poke(3, ins(0, 0)); poke(4, ins(2, 102));
        hold_reset();
        run(n);
        check("R3", "jmp+load+halt cycles", n[15:0], 16'd20);
        a_hold    = acc_dbg;
        addr_hold = mem_addr;
        we_cnt    = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (mem_we) we_cnt++;
        end
        check("R10", "still halted", {15'd0, halted}, 16'd1);
        check("R10", "acc frozen", acc_dbg, a_hold);
        check("R10", "addr frozen", {8'd0, mem_addr}, {8'd0, addr_hold});
        check("R10", "no writes", we_cnt[15:0], 16'd0);
        check("R10", "later store skipped", mem[102], 16'hDEAD);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule